// File: doc/BRIEF.md
# Linearized Track Parameter Fitter

This block turns one road's full-resolution hit coordinates, one per detector layer, into track parameters and a fit-quality figure. The track is assumed to lie inside a narrow road, so every parameter can be written as a straight line in the hit positions: an offset plus a dot product of a coefficient row with the hit vector. Quality is the sum of squares of several more such linear forms, one per geometric constraint. All offsets and coefficients are prepared ahead of time and written into a per-sector constant store. Alignment changes are applied by rewriting those constants.

A hit vector arrives with a sector index and is accepted under a valid/ready handshake, one vector per clock. After a fixed two-stage pipeline the result appears with the sector index passed through. The result carries the impact parameter, azimuth, curvature and chi-square, plus an overflow flag. The impact parameter is corrected for a displaced beam using two loadable beam-position registers and a sine/cosine table indexed by the top bits of the azimuth.

With default parameters there are 4 layers, 2 constraints and 4 sectors. Hits are 12-bit signed, constants 16-bit signed, results 16-bit signed and chi-square 24-bit unsigned.

Top module: `track_lin_fitter`

## Requirements
- R1: While reset is applied and on the first cycle after it, out_valid is 0 and in_ready is 1. All constants and both beam registers reset to zero.
- R2: Rows 0, 1 and 2 of a sector give raw d, azimuth and curvature. Each row computes v = (offset·256 + Σ_l coef_l·hit_l) >>> 8, using an arithmetic shift that floors. The result is then clamped to 16 bits signed. Azimuth is a binary angle, with a full turn equal to 65536. out_phi and out_curv are the clamped row 1 and row 2 values.
- R3: Each constraint row k (rows 3 and 4) gives a residual r_k, formed and clamped exactly as in R2. out_chi = Σ r_k², clamped to 2^24−1.
- R4: With idx = out_phi[15:10], let S(i) = round(32767·sin(2π·i/64)) and C = S((idx+16) mod 64). Then out_d = clamp16(d_raw − ((Ybeam·C − Xbeam·S(idx)) >>> 15)).
- R5: A clamp triggers when the value reaches a limit, not only when it passes it: ≥ 32767 or ≤ −32768 for 16-bit results, and ≥ 2^24−1 for chi-square. out_ovf is 1 exactly when some clamp in that fit triggered, including the clamps on the residuals and on raw d.
- R6: A vector accepted on a clock edge, with out_ready high on the next edge, appears on out_valid one edge after that. Results leave in acceptance order, and out_sector equals the input sector.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0, and every output holds its value on the next cycle.
- R8: The constant at address sector·25 + row·5 + col is written by cfg_we. Column 0 is the offset and column l+1 is the coefficient of layer l. Xbeam is at address 100 and Ybeam at address 101. A write takes effect for vectors accepted after the write's clock edge. A vector accepted on the same edge uses the old value.
- R9: Beam registers are only written while both pipeline stages are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Constant write strobe |
| cfg_addr | input | 7 | Constant or beam register address |
| cfg_data | input | 16 | Signed value to write |
| in_valid | input | 1 | Hit vector present |
| in_ready | output | 1 | Hit vector accepted this cycle |
| in_sector | input | 2 | Sector selecting the constant set |
| in_hits | input | 48 | Hits, layer l at bits [12l+11:12l], signed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts result |
| out_sector | output | 2 | Sector of the result |
| out_d | output | 16 | Beam-corrected impact parameter |
| out_phi | output | 16 | Azimuth, binary angle |
| out_curv | output | 16 | Curvature |
| out_chi | output | 24 | Chi-square |
| out_ovf | output | 1 | Some clamp triggered in this fit |

## Verification
The assertions assume that beam registers are written only when no fit is in either stage. They also assume that out_ready is a plain level that the sink may drop at any time. The stimulus keeps to the first assumption by draining the pipeline with in_valid low for several cycles before every beam write, and it never accepts a vector on the same cycle as a beam write. Constant-store writes, which R8 defines even during traffic, are mixed freely into the backpressured stream. Extreme vectors push every row and the chi-square sum to their clamps.

// File: rtl/track_lin_fitter.sv
module track_lin_fitter #(
  parameter int NL   = 4,
  parameter int NC   = 2,
  parameter int NS   = 4,
  parameter int HW   = 12,
  parameter int CW   = 16,
  parameter int OW   = 16,
  parameter int XW   = 24,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [$clog2(NS*(3+NC)*(NL+1)+2)-1:0] cfg_addr,
  input  logic [CW-1:0]        cfg_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [$clog2(NS)-1:0] in_sector,
  input  logic [NL*HW-1:0]     in_hits,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [$clog2(NS)-1:0] out_sector,
  output logic signed [OW-1:0] out_d,
  output logic signed [OW-1:0] out_phi,
  output logic signed [OW-1:0] out_curv,
  output logic [XW-1:0]        out_chi,
  output logic                 out_ovf
);
  localparam int NROW   = 3 + NC;
  localparam int RSTEP  = NL + 1;
  localparam int SSTEP  = NROW * RSTEP;
  localparam int NWORD  = NS * SSTEP;
  localparam int AW     = $clog2(NWORD + 2);
  localparam int SW     = $clog2(NS);
  localparam int ACCW   = HW + CW + $clog2(NL) + 2;
  localparam int CRW    = 2 * OW + 1;
  localparam int CSW    = 2 * OW + $clog2(NC + 1);
  localparam logic signed [ACCW-1:0] OMAX = ACCW'(2 ** (OW - 1) - 1);
  localparam logic signed [ACCW-1:0] OMIN = -OMAX - ACCW'(1);
  localparam logic signed [CSW-1:0]  CHIMAX = CSW'(2 ** XW - 1);

  logic signed [CW-1:0] cmem [NWORD];
  logic signed [CW-1:0] beam_x, beam_y;
  logic signed [HW-1:0] hv [NL];
  logic [AW-1:0] base;
  logic signed [OW-1:0] p1 [NROW];
  logic f1;
  logic v1;
  logic [SW-1:0] q_sec;
  logic signed [OW-1:0] q_par [NROW];
  logic q_ovf;
  logic adv;
  logic [5:0] idx;
  logic signed [OW-1:0] sn, cs, d2;
  logic signed [CRW-1:0] corr;
  logic signed [CSW-1:0] csum;
  logic [XW-1:0] chi2;
  logic f2;

  function automatic logic signed [OW-1:0] clampo(input logic signed [ACCW-1:0] v, inout logic f);
    logic signed [OW-1:0] r;
    if (v >= OMAX) begin
      r = OMAX[OW-1:0];
      f = 1'b1;
    end else if (v <= OMIN) begin
      r = OMIN[OW-1:0];
      f = 1'b1;
    end else begin
      r = v[OW-1:0];
    end
    return r;
  endfunction

  function automatic logic signed [OW-1:0] sin_lut(input logic [5:0] i);
    logic [4:0] k;
    logic signed [OW-1:0] m;
    k = i[4] ? 5'd16 - {1'b0, i[3:0]} : {1'b0, i[3:0]};
    case (k)
      5'd0:  m = OW'(0);
      5'd1:  m = OW'(3212);
      5'd2:  m = OW'(6393);
      5'd3:  m = OW'(9512);
      5'd4:  m = OW'(12539);
      5'd5:  m = OW'(15446);
      5'd6:  m = OW'(18204);
      5'd7:  m = OW'(20787);
      5'd8:  m = OW'(23170);
      5'd9:  m = OW'(25329);
      5'd10: m = OW'(27245);
      5'd11: m = OW'(28898);
      5'd12: m = OW'(30273);
      5'd13: m = OW'(31356);
      5'd14: m = OW'(32137);
      5'd15: m = OW'(32609);
      default: m = OW'(32767);
    endcase
    return i[5] ? -m : m;
  endfunction

  for (genvar l = 0; l < NL; l++) begin : g_hit
    assign hv[l] = in_hits[l*HW +: HW];
  end

  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;
  assign base     = AW'(in_sector) * AW'(SSTEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWORD; w++) cmem[w] <= '0;
      beam_x <= '0;
      beam_y <= '0;
    end else if (cfg_we) begin
      if (cfg_addr < AW'(NWORD)) cmem[cfg_addr] <= cfg_data;
      else if (cfg_addr == AW'(NWORD)) beam_x <= cfg_data;
      else if (cfg_addr == AW'(NWORD + 1)) beam_y <= cfg_data;
    end
  end

  always_comb begin
    logic signed [ACCW-1:0] a;
    f1 = 1'b0;
    for (int r = 0; r < NROW; r++) begin
      a = ACCW'(cmem[base + AW'(r*RSTEP)]) <<< FRAC;
      for (int l = 0; l < NL; l++)
        a = a + ACCW'(cmem[base + AW'(r*RSTEP + l + 1)]) * ACCW'(hv[l]);
      p1[r] = clampo(a >>> FRAC, f1);
    end
  end

  always_comb begin
    logic signed [CSW-1:0] rr;
    f2   = 1'b0;
    idx  = q_par[1][OW-1 -: 6];
    sn   = sin_lut(idx);
    cs   = sin_lut(idx + 6'd16);
    corr = (CRW'(beam_y) * CRW'(cs) - CRW'(beam_x) * CRW'(sn)) >>> 15;
    d2   = clampo(ACCW'(q_par[0]) - ACCW'(corr), f2);
    csum = '0;
    for (int k = 0; k < NC; k++) begin
      rr   = CSW'(q_par[3+k]);
      csum = csum + rr * rr;
    end
    if (csum >= CHIMAX) begin
      chi2 = CHIMAX[XW-1:0];
      f2   = 1'b1;
    end else begin
      chi2 = csum[XW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1         <= 1'b0;
      q_sec      <= '0;
      q_ovf      <= 1'b0;
      for (int r = 0; r < NROW; r++) q_par[r] <= '0;
      out_valid  <= 1'b0;
      out_sector <= '0;
      out_d      <= '0;
      out_phi    <= '0;
      out_curv   <= '0;
      out_chi    <= '0;
      out_ovf    <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      if (in_valid) begin
        q_sec <= in_sector;
        q_par <= p1;
        q_ovf <= f1;
      end
      out_valid <= v1;
      if (v1) begin
        out_sector <= q_sec;
        out_d      <= d2;
        out_phi    <= q_par[1];
        out_curv   <= q_par[2];
        out_chi    <= chi2;
        out_ovf    <= q_ovf | f2;
      end
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_d) && $stable(out_phi)
      && $stable(out_curv) && $stable(out_chi) && $stable(out_sector) && $stable(out_ovf));

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_d == OMAX[OW-1:0] || out_d == OMIN[OW-1:0]
      || out_phi == OMAX[OW-1:0] || out_phi == OMIN[OW-1:0]
      || out_curv == OMAX[OW-1:0] || out_curv == OMIN[OW-1:0]
      || out_chi == CHIMAX[XW-1:0]) |-> out_ovf);

  // R9
  beam_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr >= AW'(NWORD) |-> !v1 && !out_valid);
endmodule

// File: tb/track_lin_fitter_bench.sv
module track_lin_fitter_bench;
  localparam int NL = 4, NC = 2, NS = 4, HW = 12;
  localparam int RSTEP = NL + 1, SSTEP = (3 + NC) * RSTEP, NWORD = NS * SSTEP;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_sector = '0;
  logic [NL*HW-1:0] in_hits = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [1:0] out_sector;
  logic signed [15:0] out_d, out_phi, out_curv;
  logic [23:0] out_chi;
  logic out_ovf;

  always #10 clk = ~clk;

  track_lin_fitter u_track_lin_fitter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_sector(in_sector), .in_hits(in_hits),
    .out_valid(out_valid), .out_ready(out_ready), .out_sector(out_sector),
    .out_d(out_d), .out_phi(out_phi), .out_curv(out_curv), .out_chi(out_chi), .out_ovf(out_ovf)
  );

  typedef struct {
    int sec; longint d; longint phi; longint curv; longint chi; bit ovf; int cyc;
  } res_t;

  res_t q[$];
  longint mm [NWORD + 2];
  int checks = 0, errors = 0, cyc = 0;
  bit lat_mode = 1'b0;
  bit hold_pend = 1'b0;
  logic [15:0] hd, hp, hc2;
  logic [23:0] hx;
  logic [1:0] hs;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clampv(longint v, longint lo, longint hi, inout bit f);
    if (v >= hi) begin f = 1'b1; return hi; end
    if (v <= lo) begin f = 1'b1; return lo; end
    return v;
  endfunction

  function automatic longint trig(int i);
    real x;
    x = 32767.0 * $sin(2.0 * PI * i / 64.0);
    return (x < 0.0) ? -longint'($rtoi(-x + 0.5)) : longint'($rtoi(x + 0.5));
  endfunction

  function automatic res_t ref_fit(int sec, logic [NL*HW-1:0] hits);
    res_t e;
    longint p [5];
    longint acc, sv, cv, corr;
    bit f = 1'b0;
    int ix;
    for (int r = 0; r < 5; r++) begin
      acc = mm[sec*SSTEP + r*RSTEP] * 256;
      for (int l = 0; l < NL; l++)
        acc += mm[sec*SSTEP + r*RSTEP + l + 1] * longint'($signed(hits[l*HW +: HW]));
      p[r] = clampv(acc >>> 8, -32768, 32767, f);
    end
    e.chi = 0;
    for (int k = 0; k < NC; k++) e.chi += p[3+k] * p[3+k];
    e.chi = clampv(e.chi, -1, 16777215, f);
    ix = int'((p[1] & 64'hFFFF) >> 10);
    sv = trig(ix);
    cv = trig((ix + 16) % 64);
    corr = (mm[NWORD+1] * cv - mm[NWORD] * sv) >>> 15;
    e.d = clampv(p[0] - corr, -32768, 32767, f);
    e.phi = p[1];
    e.curv = p[2];
    e.sec = sec;
    e.ovf = f;
    e.cyc = cyc;
    return e;
  endfunction

  task automatic mon();
    res_t e;
    if (hold_pend) begin
      chk(out_valid === 1'b1, "R7 valid held", longint'(out_valid), 1);
      chk(out_d === hd && out_phi === hp && out_curv === hc2 && out_chi === hx && out_sector === hs,
          "R7 data held", longint'(out_d), longint'($signed(hd)));
    end
    hold_pend = 1'b0;
    if (out_valid) begin
      if (out_ready) begin
        if (q.size() == 0) chk(1'b0, "R6 unexpected result", 1, 0);
        else begin
          e = q.pop_front();
          chk(int'(out_sector) == e.sec, "R6 sector/order", longint'(out_sector), e.sec);
          chk(longint'(out_d) == e.d, "R4 d", longint'(out_d), e.d);
          chk(longint'(out_phi) == e.phi, "R2 phi", longint'(out_phi), e.phi);
          chk(longint'(out_curv) == e.curv, "R2 curv", longint'(out_curv), e.curv);
          chk(longint'(out_chi) == e.chi, "R3 chi", longint'(out_chi), e.chi);
          chk(out_ovf == e.ovf, "R5 ovf", longint'(out_ovf), longint'(e.ovf));
          if (lat_mode) chk(cyc - e.cyc == 2, "R6 latency", cyc - e.cyc, 2);
        end
      end else begin
        chk(in_ready == 1'b0, "R7 in_ready low", longint'(in_ready), 0);
        hold_pend = 1'b1;
        hd = out_d; hp = out_phi; hc2 = out_curv; hx = out_chi; hs = out_sector;
      end
    end
    if (in_valid && in_ready) q.push_back(ref_fit(int'(in_sector), in_hits));
    if (cfg_we && int'(cfg_addr) < NWORD + 2) mm[cfg_addr] = longint'($signed(cfg_data));
  endtask

  task automatic tick();
    #1;
    mon();
    @(negedge clk);
    cyc++;
  endtask

  task automatic cfg_write(int a, logic [15:0] v);
    cfg_we = 1'b1; cfg_addr = 7'(a); cfg_data = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (5) tick();
  endtask

  function automatic logic [NL*HW-1:0] rnd_hits();
    return (NL*HW)'({$urandom(), $urandom()});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < NWORD + 2; w++) mm[w] = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);

    // R8 / R4 directed: sector 3 only curvature offset, beam Y = 1000
    cfg_write(3*SSTEP + 2*RSTEP, 16'd100);
    cfg_write(NWORD + 1, 16'd1000);
    tick();
    in_valid = 1'b1; in_sector = 2'd3; in_hits = rnd_hits();
    tick();
    in_valid = 1'b0;
    tick();
    chk(out_valid == 1'b1, "R6 directed valid", longint'(out_valid), 1);
    chk(longint'(out_curv) == 100, "R8 loaded offset", longint'(out_curv), 100);
    chk(longint'(out_d) == -999, "R4 beam correction", longint'(out_d), -999);
    chk(out_chi == 24'd0, "R3 zero constraints", longint'(out_chi), 0);
    drain();

    // random small constants, full-rate stream
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < SSTEP; w++)
        cfg_write(s*SSTEP + w, 16'($urandom_range(0, 511)) - 16'd256);
    cfg_write(NWORD, 16'($urandom_range(0, 4000)) - 16'd2000);
    cfg_write(NWORD + 1, 16'($urandom_range(0, 4000)) - 16'd2000);
    tick();
    lat_mode = 1'b1;
    for (int n = 0; n < 200; n++) begin
      in_valid = 1'b1; in_sector = 2'($urandom()); in_hits = rnd_hits();
      tick();
    end
    drain();
    lat_mode = 1'b0;

    // backpressure with constant rewrites in traffic (R7, R8)
    for (int n = 0; n < 400; n++) begin
      in_valid = ($urandom_range(0, 3) != 0);
      in_sector = 2'($urandom()); in_hits = rnd_hits();
      out_ready = ($urandom_range(0, 9) < 7);
      cfg_we = ($urandom_range(0, 7) == 0);
      cfg_addr = 7'($urandom_range(0, NWORD - 1));
      cfg_data = 16'($urandom());
      tick();
    end
    cfg_we = 1'b0;
    drain();

    // extreme values: every clamp reached (R5)
    for (int w = 0; w < SSTEP; w++) begin
      cfg_write(SSTEP + w, (w % RSTEP == 0) ? 16'h7FFF : 16'h8000);
      cfg_write(2*SSTEP + w, (w % RSTEP == 0) ? 16'h8000 : 16'h7FFF);
    end
    cfg_write(NWORD, 16'h7FFF);
    cfg_write(NWORD + 1, 16'h8000);
    tick();
    for (int n = 0; n < 60; n++) begin
      in_valid = 1'b1; in_sector = 2'($urandom_range(0, 3));
      case (n % 4)
        0: in_hits = {NL{12'h800}};
        1: in_hits = {NL{12'h7FF}};
        2: in_hits = '0;
        default: in_hits = rnd_hits();
      endcase
      out_ready = (n % 3 != 1);
      tick();
    end
    drain();
    chk(q.size() == 0, "R6 all results delivered", q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule